// File: doc/BRIEF.md
# Watchdog Timer with Single or Paired Clear

This block is a free-running supervision counter. It advances on every cycle in which its tick enable is high and the watchdog is switched on. Software must restart it before it rolls over; otherwise the block raises a one-cycle chip reset request. If the system is halted when the roll-over happens, the block raises a one-cycle wake request instead, and the system reset is not requested.

A mode input chooses how software restarts the count. In single mode, either of the two clear commands restarts it at once. In paired mode, both distinct commands must have arrived. A command that arrives first is held until its partner comes. Sending the same command again does not complete the pair.

The block also keeps two status bits. The time-out bit records that a roll-over happened. The power-down bit records that the system entered halt. A successful restart clears both bits. Only the block's own logic drives these bits: nothing outside can write them.

Top module: `watchdog_dualclr`

## Requirements
- R1: While reset is asserted and directly after it, `rst_req`, `wake_req`, `to_flag` and `pdf_flag` are 0 and the count is 0.
- R2: While `wdt_on` is 0 the count does not advance, and neither `rst_req` nor `wake_req` is raised.
- R3: The count starts from 0 at reset release and advances on each cycle in which `wdt_on` and `tick_en` are both 1. The tick that arrives while the count is all ones (the 2^CNT_W-th tick) is a time-out, and `rst_req` is 1 for exactly the one cycle after that edge.
- R4: With `pair_mode` = 0, a pulse on either `clr_a` or `clr_b` sets the count to 0 on that edge. The next time-out then needs another 2^CNT_W ticks.
- R5: With `pair_mode` = 1, the count restarts on the edge where both commands have been seen. Each command counts if it is present in that cycle or if it is held from an earlier cycle. Both commands in one cycle also restart the count.
- R6: With `pair_mode` = 1, any number of pulses on only one of the two commands never restarts the count, so the time-out still occurs on schedule.
- R7: A time-out sets `to_flag` to 1 on the same edge that raises `rst_req` or `wake_req`.
- R8: A restart clears both `to_flag` and `pdf_flag` on its edge.
- R9: On the edge after `halted` goes from 0 to 1, `pdf_flag` is 1. This holds even if a restart falls on the same edge.
- R10: A time-out while `halted` is 1 raises `wake_req` for one cycle, keeps `rst_req` at 0, and leaves `pdf_flag` unchanged.
- R11: A restart that falls on the same edge as a roll-over wins: no time-out occurs, and the count goes to 0.
- R12: While `tick_en` is 0 the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Count enable from the watchdog's own time base |
| wdt_on | input | 1 | Watchdog enable option |
| pair_mode | input | 1 | 0: one clear command restarts; 1: both commands are required |
| clr_a | input | 1 | First clear command pulse |
| clr_b | input | 1 | Second clear command pulse |
| halted | input | 1 | System is in halt state |
| rst_req | output | 1 | One-cycle chip reset request on a time-out while running |
| wake_req | output | 1 | One-cycle wake request on a time-out while halted |
| to_flag | output | 1 | Time-out status bit |
| pdf_flag | output | 1 | Power-down status bit |

## Verification
A restart command and a counter roll-over can fall on the same clock edge. To provoke this, the bench lets the count reach all ones and drives a clear pulse into exactly the cycle whose edge would roll it over. The result is judged correct when no reset request appears, the time-out bit stays 0, and the next time-out arrives a full period later. That last point proves the count went to 0. Halt entry and a time-out are also brought together on one edge, and the wake request is checked in place of a reset request.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic {
        CLR_SINGLE = 1'b0,
        CLR_PAIR   = 1'b1
    } clr_mode_e;

    typedef struct packed {
        logic held_a;
        logic held_b;
    } pend_t;

    typedef struct packed {
        logic to_bit;
        logic pdf_bit;
        logic halt_seen;
        logic rst_pulse;
        logic wake_pulse;
    } flag_t;

endpackage

// File: rtl/wdg_counter.sv
module wdg_counter #(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tmo
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tmo  = run && (st_q.cnt == CNT_MAX) && !restart;
        if (restart) begin
            st_d.cnt = '0;
        end else if (run) begin
            st_d.cnt = st_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wdg_clear_qual.sv
module wdg_clear_qual
    import wdg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  clr_mode_e mode,
    input  logic      clr_a,
    input  logic      clr_b,
    input  logic      tmo,
    output logic      restart
);
    pend_t pend_d, pend_q;
    logic  seen_a, seen_b;

    always_comb begin
        seen_a  = clr_a || pend_q.held_a;
        seen_b  = clr_b || pend_q.held_b;
        pend_d  = '0;
        restart = 1'b0;
        if (mode == CLR_SINGLE) begin
            restart = clr_a || clr_b;
        end else begin
            restart = seen_a && seen_b;
            if (!restart && !tmo) begin
                pend_d.held_a = seen_a;
                pend_d.held_b = seen_b;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

endmodule

// File: rtl/wdg_flags.sv
module wdg_flags
    import wdg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halted,
    input  logic tmo,
    input  logic restart,
    output logic rst_req,
    output logic wake_req,
    output logic to_flag,
    output logic pdf_flag
);
    flag_t fl_d, fl_q;

    always_comb begin
        fl_d            = fl_q;
        fl_d.halt_seen  = halted;
        fl_d.rst_pulse  = tmo && !halted;
        fl_d.wake_pulse = tmo && halted;
        if (restart) begin
            fl_d.to_bit  = 1'b0;
            fl_d.pdf_bit = 1'b0;
        end
        if (tmo) begin
            fl_d.to_bit = 1'b1;
        end
        if (halted && !fl_q.halt_seen) begin
            fl_d.pdf_bit = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign rst_req  = fl_q.rst_pulse;
    assign wake_req = fl_q.wake_pulse;
    assign to_flag  = fl_q.to_bit;
    assign pdf_flag = fl_q.pdf_bit;

endmodule

// File: rtl/watchdog_dualclr.sv
module watchdog_dualclr
    import wdg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic wdt_on,
    input  logic pair_mode,
    input  logic clr_a,
    input  logic clr_b,
    input  logic halted,
    output logic rst_req,
    output logic wake_req,
    output logic to_flag,
    output logic pdf_flag
);
    logic      run;
    logic      restart;
    logic      tmo;
    clr_mode_e mode;

    assign run  = wdt_on && tick_en;
    assign mode = clr_mode_e'(pair_mode);

    wdg_clear_qual u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .clr_a   (clr_a),
        .clr_b   (clr_b),
        .tmo     (tmo),
        .restart (restart)
    );

    wdg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .tmo     (tmo)
    );

    wdg_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .halted   (halted),
        .tmo      (tmo),
        .restart  (restart),
        .rst_req  (rst_req),
        .wake_req (wake_req),
        .to_flag  (to_flag),
        .pdf_flag (pdf_flag)
    );

endmodule

// File: rtl/watchdog_dualclr_chk.sv
module watchdog_dualclr_chk (
    input logic clk,
    input logic rst_n,
    input logic tick_en,
    input logic wdt_on,
    input logic pair_mode,
    input logic clr_a,
    input logic clr_b,
    input logic halted,
    input logic rst_req,
    input logic wake_req,
    input logic to_flag,
    input logic pdf_flag
);
    a_r2_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || wake_req) |-> $past(wdt_on));

    a_r12_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || wake_req) |-> $past(tick_en));

    a_r7_to_with_event: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || wake_req) |-> to_flag);

    a_r10_wake_only_halted: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(halted));

    a_r10_reset_only_running: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !$past(halted));

    a_r11_clear_beats_rollover: assert property (@(posedge clk) disable iff (!rst_n)
        (!pair_mode && (clr_a || clr_b)) |=> (!to_flag && !rst_req && !wake_req));

    a_r9_halt_sets_pdf: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |=> pdf_flag);

endmodule

bind watchdog_dualclr watchdog_dualclr_chk u_chk (.*);

// File: tb/watchdog_dualclr_tb.sv
`timescale 1ns/1ps
module watchdog_dualclr_tb;
    localparam int W      = 4;
    localparam int PERIOD = 1 << W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0, wdt_on = 1'b0, pair_mode = 1'b0;
    logic clr_a = 1'b0, clr_b = 1'b0, halted = 1'b0;
    logic rst_req, wake_req, to_flag, pdf_flag;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    watchdog_dualclr #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wdt_on(wdt_on),
        .pair_mode(pair_mode), .clr_a(clr_a), .clr_b(clr_b), .halted(halted),
        .rst_req(rst_req), .wake_req(wake_req), .to_flag(to_flag), .pdf_flag(pdf_flag)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic on, input logic mode);
        @(negedge clk);
        rst_n = 1'b0; clr_a = 1'b0; clr_b = 1'b0; halted = 1'b0;
        step(2);
        wdt_on = on; pair_mode = mode; tick_en = 1'b1;
        rst_n = 1'b1;
    endtask

    task automatic pulse(input logic a, input logic b);
        clr_a = a; clr_b = b;
        step(1);
        clr_a = 1'b0; clr_b = 1'b0;
    endtask

    // quiet for n cycles, then a reset request on the next
    task automatic expect_fire(input string req, input int n);
        logic early = 1'b0;
        for (int i = 0; i < n; i++) begin
            step(1);
            if (rst_req || wake_req) early = 1'b1;
        end
        check(req, "no early request", early, 1'b0);
        step(1);
        check(req, "rst_req at time-out", rst_req, 1'b1);
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        step(2);
        check("R1", "rst_req in reset", rst_req, 1'b0);
        check("R1", "to_flag in reset", to_flag, 1'b0);
        do_reset(1'b1, 1'b0);
        check("R1", "wake_req after reset", wake_req, 1'b0);
        check("R1", "pdf_flag after reset", pdf_flag, 1'b0);
    endtask

    task automatic t_disabled();
        logic any = 1'b0;
        do_reset(1'b0, 1'b0);
        for (int i = 0; i < 3 * PERIOD; i++) begin
            step(1);
            if (rst_req || wake_req) any = 1'b1;
        end
        check("R2", "no request while off", any, 1'b0);
        check("R2", "to_flag while off", to_flag, 1'b0);
    endtask

    task automatic t_timeout_from_reset();
        do_reset(1'b1, 1'b0);
        expect_fire("R3", PERIOD - 1);
        check("R7", "to_flag on time-out", to_flag, 1'b1);
        step(1);
        check("R3", "rst_req lasts one cycle", rst_req, 1'b0);
    endtask

    task automatic t_single_clear();
        do_reset(1'b1, 1'b0);
        halted = 1'b1;
        step(1);
        halted = 1'b0;
        step(PERIOD - 1);
        check("R3", "rst_req after halt exit", rst_req, 1'b1);
        check("R9", "pdf_flag after halt entry", pdf_flag, 1'b1);
        check("R7", "to_flag set", to_flag, 1'b1);
        step(3);
        pulse(1'b0, 1'b1);
        check("R8", "to_flag cleared", to_flag, 1'b0);
        check("R8", "pdf_flag cleared", pdf_flag, 1'b0);
        expect_fire("R4", PERIOD - 1);
    endtask

    task automatic t_pair_one_only();
        do_reset(1'b1, 1'b1);
        step(3); pulse(1'b1, 1'b0);
        step(3); pulse(1'b1, 1'b0);
        expect_fire("R6", PERIOD - 9);
    endtask

    task automatic t_pair_split();
        do_reset(1'b1, 1'b1);
        step(5); pulse(1'b1, 1'b0);
        step(4); pulse(1'b0, 1'b1);
        expect_fire("R5", PERIOD - 1);
    endtask

    task automatic t_pair_same_cycle();
        do_reset(1'b1, 1'b1);
        step(5); pulse(1'b1, 1'b1);
        expect_fire("R5", PERIOD - 1);
    endtask

    task automatic t_halt_wake();
        do_reset(1'b1, 1'b0);
        halted = 1'b1;
        step(1);
        check("R9", "pdf_flag on halt", pdf_flag, 1'b1);
        step(PERIOD - 2);
        check("R10", "no wake early", wake_req, 1'b0);
        step(1);
        check("R10", "wake_req on halted time-out", wake_req, 1'b1);
        check("R10", "rst_req held low", rst_req, 1'b0);
        check("R10", "pdf_flag kept", pdf_flag, 1'b1);
        check("R7", "to_flag on halted time-out", to_flag, 1'b1);
        step(1);
        check("R10", "wake_req one cycle", wake_req, 1'b0);
        halted = 1'b0;
    endtask

    task automatic t_collision();
        do_reset(1'b1, 1'b0);
        step(PERIOD - 1);
        check("R11", "no request before roll-over", rst_req, 1'b0);
        pulse(1'b1, 1'b0);
        check("R11", "clear wins, no rst_req", rst_req, 1'b0);
        check("R11", "clear wins, to_flag low", to_flag, 1'b0);
        expect_fire("R11", PERIOD - 1);
    endtask

    task automatic t_tick_gate();
        do_reset(1'b1, 1'b0);
        tick_en = 1'b0;
        step(3 * PERIOD);
        check("R12", "held count gives no request", rst_req, 1'b0);
        tick_en = 1'b1;
        expect_fire("R12", PERIOD - 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, got hang expected end");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_disabled();
        t_timeout_from_reset();
        t_single_clear();
        t_pair_one_only();
        t_pair_split();
        t_pair_same_cycle();
        t_halt_wake();
        t_collision();
        t_tick_gate();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule